// File: doc/BRIEF.md
# Multi-stop time-of-flight measurement sequencer

This block is the digital controller of a stopwatch-style time measurement. A one-cycle start request from the register side makes it drive a trigger output toward an external front end and arm itself for a START edge. Once START arrives it counts reference-clock cycles. It ignores STOP edges until a programmable blanking count has passed, then records the cycle count at each STOP edge until the requested number of stops has been taken. A calibration phase of selectable length follows.

A measurement can be repeated a programmable number of times for averaging. A new trigger is issued automatically between repetitions, and the per-stop counts are summed into wide accumulators. Two overflow checks end the measurement at once: one on the clock count and one on a fine-time count supplied by an external interval model. Sticky flags report completion and each kind of overflow to the surrounding status logic.

The controller has four states. IDLE waits for a start request. ARM drives the trigger and waits for START. RUN counts and captures stops. CAL times the calibration window. The transitions are:
- IDLE to ARM on a start request.
- ARM to RUN on a START edge.
- RUN to CAL on the last expected stop, or on an overflow with forced calibration.
- RUN to IDLE on an overflow without forced calibration.
- CAL to ARM when averaging cycles remain.
- CAL to IDLE after the final cycle or after an abort.

Top module: `tof_sequencer`

## Requirements
- R1: After reset the block is idle. `busy`, `cal_active` and all flags are 0, every accumulator is 0, and `trig_out` equals `trig_pol`. In the cycle after `start_req` is sampled in idle, `busy` is 1 and `trig_out` is at its active level (`~trig_pol`). `trig_out` returns to `trig_pol` two cycles after the edge that samples the START edge.
- R2: While armed, the block waits for START with no time limit. `busy` and the active trigger level hold for as long as START is absent.
- R3: The value recorded for a STOP equals the number of rising reference edges from the edge that samples the START edge to the edge that samples the STOP edge.
- R4: A STOP edge whose count is below `mask_val` is ignored. A count equal to `mask_val` is accepted. Stops that are accepted fill accumulator slots 0, 1, 2 and so on, in order.
- R5: `stop_code` values 0 to 4 select 1 to 5 stops, and values 5 to 7 select a single stop. Stops beyond the selected number leave the accumulators unchanged.
- R6: When the count exceeds `clk_ovf_thr`, the block sets `clk_ovf_flag` and ends the measurement without setting `done_flag`. A stop seen at a count equal to the threshold is still recorded.
- R7: When `fine_cnt / 63 >= coarse_ovf_thr` during counting, the block sets `coarse_ovf_flag` and ends the measurement without setting `done_flag`. When the quotient is below the threshold, the measurement is not affected.
- R8: `avg_code` k runs 2^k measurement cycles. `trig_out` becomes active again automatically between cycles while `done_flag` stays 0. Each slot holds the sum of its per-cycle counts, and `done_flag` is set only after the last cycle.
- R9: A start request in idle clears every accumulator and flag. `busy` falls when the sequence ends. A start request while busy has no effect.
- R10: The calibration phase keeps `cal_active` high for 2, 10, 20 or 40 cycles for `cal_code` 0, 1, 2 or 3. `trig_out` stays idle during calibration. After an overflow, calibration runs only when `force_cal` is 1.
- R11: `start_pol` and `stop_pol` set to 1 select falling edges, and 0 selects rising edges. `trig_pol` set to 1 makes the trigger idle high and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle request to begin a measurement |
| start_pol | input | 1 | START edge select, 0 rising, 1 falling |
| stop_pol | input | 1 | STOP edge select, 0 rising, 1 falling |
| trig_pol | input | 1 | Trigger idle level; active level is its inverse |
| stop_code | input | 3 | Number of stops to take (0..4 give 1..5; others give 1) |
| avg_code | input | 3 | Log2 of the number of averaging cycles |
| cal_code | input | 2 | Calibration length select: 2, 10, 20 or 40 cycles |
| force_cal | input | 1 | Run calibration even after an overflow |
| mask_val | input | 16 | Count below which STOP edges are ignored |
| clk_ovf_thr | input | 16 | Clock-count overflow threshold |
| coarse_ovf_thr | input | 16 | Fine-time overflow threshold (in units of 63) |
| fine_cnt | input | 24 | Fine-time count from the external interval model |
| start_in | input | 1 | Asynchronous START input |
| stop_in | input | 1 | Asynchronous STOP input |
| trig_out | output | 1 | Trigger to the external front end |
| busy | output | 1 | Measurement sequence in progress; self-clearing start bit |
| cal_active | output | 1 | Calibration window in progress |
| done_flag | output | 1 | Sticky: sequence finished normally |
| clk_ovf_flag | output | 1 | Sticky: clock-count overflow ended the sequence |
| coarse_ovf_flag | output | 1 | Sticky: fine-time overflow ended the sequence |
| acc_flat | output | 115 | Five 23-bit stop accumulators, slot 0 in the low bits |

## Verification
The assertions assume that `start_req` is a single-cycle pulse. They also assume that the polarity, code and threshold inputs change only while the block is idle, and that `start_in` and `stop_in` change at most once per reference cycle. The stimulus follows these rules. It drives every control input at the falling clock edge, and it changes a pin level together with its polarity select so that the synchronizers see no false edge. It spaces STOP pulses at least two cycles apart, so each one reaches the edge detector as a separate rising transition.

// File: rtl/tof_pkg.sv
package tof_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARM  = 2'd1,
        S_RUN  = 2'd2,
        S_CAL  = 2'd3
    } tof_state_e;

    // index of the last stop to take; out-of-range codes fall back to one stop
    function automatic logic [2:0] last_stop_idx(input logic [2:0] code);
        return (code <= 3'd4) ? code : 3'd0;
    endfunction

    // calibration window length in reference cycles
    function automatic logic [5:0] cal_len(input logic [1:0] code);
        logic [5:0] len;
        unique case (code)
            2'd0:    len = 6'd2;
            2'd1:    len = 6'd10;
            2'd2:    len = 6'd20;
            default: len = 6'd40;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/tof_edge_sync.sv
module tof_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic pol,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], din ^ pol};
        end
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tof_ovf_chk.sv
module tof_ovf_chk #(
    parameter int CNT_W  = 16,
    parameter int FINE_W = 24
) (
    input  logic [CNT_W:0]    cnt,
    input  logic [CNT_W-1:0]  clk_thr,
    input  logic [CNT_W-1:0]  coarse_thr,
    input  logic [FINE_W-1:0] fine,
    output logic              clk_hit,
    output logic              coarse_hit
);
    localparam int PROD_W = CNT_W + 6;
    localparam int CMP_W  = (FINE_W > PROD_W) ? FINE_W : PROD_W;

    logic [PROD_W-1:0] lim;

    // floor(fine/63) >= thr  <=>  fine >= 63*thr
    assign lim        = PROD_W'(coarse_thr) * PROD_W'(63);
    assign coarse_hit = CMP_W'(fine) >= CMP_W'(lim);
    assign clk_hit    = cnt > {1'b0, clk_thr};
endmodule

// File: rtl/tof_accum.sv
module tof_accum #(
    parameter int NSTOP = 5,
    parameter int CNT_W = 16,
    parameter int ACC_W = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     add_en,
    input  logic [$clog2(NSTOP)-1:0] idx,
    input  logic [CNT_W-1:0]         val,
    output logic [NSTOP*ACC_W-1:0]   acc_flat
);
    localparam int IDX_W = $clog2(NSTOP);

    for (genvar g = 0; g < NSTOP; g++) begin : g_slot
        logic [ACC_W-1:0] acc;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc <= '0;
            end else if (clr) begin
                acc <= '0;
            end else if (add_en && idx == IDX_W'(g)) begin
                acc <= acc + ACC_W'(val);
            end
        end

        assign acc_flat[g*ACC_W +: ACC_W] = acc;
    end
endmodule

// File: rtl/tof_sequencer.sv
module tof_sequencer
    import tof_pkg::*;
#(
    parameter int NSTOP       = 5,
    parameter int CNT_W       = 16,
    parameter int FINE_W      = 24,
    parameter int ACC_W       = 23,
    parameter int AVG_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_req,
    input  logic                   start_pol,
    input  logic                   stop_pol,
    input  logic                   trig_pol,
    input  logic [2:0]             stop_code,
    input  logic [AVG_W-1:0]       avg_code,
    input  logic [1:0]             cal_code,
    input  logic                   force_cal,
    input  logic [CNT_W-1:0]       mask_val,
    input  logic [CNT_W-1:0]       clk_ovf_thr,
    input  logic [CNT_W-1:0]       coarse_ovf_thr,
    input  logic [FINE_W-1:0]      fine_cnt,
    input  logic                   start_in,
    input  logic                   stop_in,
    output logic                   trig_out,
    output logic                   busy,
    output logic                   cal_active,
    output logic                   done_flag,
    output logic                   clk_ovf_flag,
    output logic                   coarse_ovf_flag,
    output logic [NSTOP*ACC_W-1:0] acc_flat
);
    localparam int IDX_W = $clog2(NSTOP);
    localparam int CYC_W = 1 << AVG_W;

    tof_state_e        state, nxt;
    logic [CNT_W:0]    cnt;
    logic [IDX_W-1:0]  stop_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [CYC_W-1:0]  cyc, cyc_last;
    logic [5:0]        cal_cnt;
    logic              cal_end;
    logic              aborted;
    logic              done_q, clk_ovf_q, coarse_ovf_q;
    logic              start_rise, stop_rise;
    logic              clk_hit, coarse_hit, ovf_hit;
    logic              stop_ok, cap_en, acc_clr;

    tof_edge_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
        .clk(clk), .rst_n(rst_n), .din(start_in), .pol(start_pol), .rise(start_rise)
    );

    tof_edge_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
        .clk(clk), .rst_n(rst_n), .din(stop_in), .pol(stop_pol), .rise(stop_rise)
    );

    tof_ovf_chk #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_ovf (
        .cnt(cnt), .clk_thr(clk_ovf_thr), .coarse_thr(coarse_ovf_thr),
        .fine(fine_cnt), .clk_hit(clk_hit), .coarse_hit(coarse_hit)
    );

    assign last_idx = IDX_W'(last_stop_idx(stop_code));
    assign cyc_last = (CYC_W'(1) << avg_code) - CYC_W'(1);
    assign ovf_hit  = state == S_RUN && (clk_hit || coarse_hit);
    assign stop_ok  = stop_rise && cnt >= {1'b0, mask_val};
    assign cap_en   = state == S_RUN && !ovf_hit && stop_ok;
    assign acc_clr  = state == S_IDLE && start_req;
    assign cal_end  = cal_cnt == cal_len(cal_code) - 6'd1;

    tof_accum #(.NSTOP(NSTOP), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add_en(cap_en),
        .idx(stop_idx), .val(cnt[CNT_W-1:0]), .acc_flat(acc_flat)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start_req) nxt = S_ARM;
            S_ARM:  if (start_rise) nxt = S_RUN;
            S_RUN: begin
                if (ovf_hit) begin
                    nxt = force_cal ? S_CAL : S_IDLE;
                end else if (stop_ok && stop_idx == last_idx) begin
                    nxt = S_CAL;
                end
            end
            S_CAL: begin
                if (cal_end) begin
                    nxt = (aborted || cyc == cyc_last) ? S_IDLE : S_ARM;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // counters and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt          <= '0;
            stop_idx     <= '0;
            cyc          <= '0;
            cal_cnt      <= '0;
            aborted      <= 1'b0;
            done_q       <= 1'b0;
            clk_ovf_q    <= 1'b0;
            coarse_ovf_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start_req) begin
                        cyc          <= '0;
                        aborted      <= 1'b0;
                        done_q       <= 1'b0;
                        clk_ovf_q    <= 1'b0;
                        coarse_ovf_q <= 1'b0;
                    end
                end
                S_ARM: begin
                    if (start_rise) begin
                        cnt      <= {{CNT_W{1'b0}}, 1'b1};
                        stop_idx <= '0;
                    end
                end
                S_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (ovf_hit) begin
                        aborted      <= 1'b1;
                        clk_ovf_q    <= clk_hit;
                        coarse_ovf_q <= coarse_hit;
                    end else if (stop_ok) begin
                        stop_idx <= stop_idx + 1'b1;
                    end
                end
                S_CAL: begin
                    if (cal_end && !aborted) begin
                        if (cyc == cyc_last) begin
                            done_q <= 1'b1;
                        end else begin
                            cyc <= cyc + 1'b1;
                        end
                    end
                end
            endcase
            cal_cnt <= (state == S_CAL) ? cal_cnt + 6'd1 : 6'd0;
        end
    end

    // outputs
    always_comb begin
        busy            = state != S_IDLE;
        trig_out        = trig_pol ^ (state == S_ARM);
        cal_active      = state == S_CAL;
        done_flag       = done_q;
        clk_ovf_flag    = clk_ovf_q;
        coarse_ovf_flag = coarse_ovf_q;
    end
endmodule

// File: rtl/tof_sequencer_chk.sv
module tof_sequencer_chk
    import tof_pkg::*;
#(
    parameter int ACC_BITS = 115
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_req,
    input logic                busy,
    input logic                trig_out,
    input logic                trig_pol,
    input logic                cal_active,
    input logic                done_flag,
    input logic                clk_ovf_flag,
    input logic                cap_en,
    input logic                acc_clr,
    input tof_state_e          state,
    input logic [ACC_BITS-1:0] acc_flat
);
    // R9: an idle start request always begins a sequence
    a_r9_req_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req) |=> busy);

    // R5: accumulators move only on a capture strobe or a clear
    a_r5_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !acc_clr) |=> $stable(acc_flat));

    // R6: a clock overflow takes the controller out of counting
    a_r6_ovf_leaves_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_ovf_flag) |-> (state != S_RUN));

    // R8: completion is reported only once the sequence is over
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag |-> !busy);

    // R10: no trigger while calibrating
    a_r10_cal_no_trig: assert property (@(posedge clk) disable iff (!rst_n)
        cal_active |-> (trig_out == trig_pol));
endmodule

bind tof_sequencer tof_sequencer_chk #(.ACC_BITS(NSTOP*ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .busy(busy),
    .trig_out(trig_out), .trig_pol(trig_pol), .cal_active(cal_active),
    .done_flag(done_flag), .clk_ovf_flag(clk_ovf_flag), .cap_en(cap_en),
    .acc_clr(acc_clr), .state(state), .acc_flat(acc_flat)
);

// File: tb/tof_sequencer_tb.sv
`timescale 1ns/1ps
module tof_sequencer_tb;
    localparam int NS = 5;
    localparam int AW = 23;

    typedef struct packed {
        logic [15:0] mask;
        logic [2:0]  code;
        logic [2:0]  avg;
        logic [7:0]  d0;
        logic [7:0]  gap;
        logic [3:0]  ne;
        logic [23:0] exp0;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{16'd0,  3'd0, 3'd0, 8'd5,  8'd4, 4'd1, 24'd5},
        '{16'd0,  3'd2, 3'd0, 8'd4,  8'd3, 4'd3, 24'd4},
        '{16'd10, 3'd1, 3'd0, 8'd3,  8'd5, 4'd5, 24'd13},
        '{16'd0,  3'd4, 3'd1, 8'd3,  8'd3, 4'd5, 24'd6},
        '{16'd0,  3'd6, 3'd2, 8'd7,  8'd3, 4'd3, 24'd28},
        '{16'd20, 3'd0, 3'd0, 8'd20, 8'd2, 4'd1, 24'd20}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic        start_pol = 1'b0, stop_pol = 1'b0, trig_pol = 1'b0;
    logic [2:0]  stop_code = '0, avg_code = '0;
    logic [1:0]  cal_code = 2'd1;
    logic        force_cal = 1'b0;
    logic [15:0] mask_val = '0, clk_ovf_thr = 16'hFFFF, coarse_ovf_thr = 16'hFFFF;
    logic [23:0] fine_cnt = '0;
    logic        start_in = 1'b0, stop_in = 1'b0;
    logic        trig_out, busy, cal_active, done_flag, clk_ovf_flag, coarse_ovf_flag;
    logic [NS*AW-1:0] acc_flat;

    int checks = 0;
    int fails  = 0;
    int cal_seen = 0;
    int trig_count = 0;
    int wd = 0;

    tof_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_pol(start_pol),
        .stop_pol(stop_pol), .trig_pol(trig_pol), .stop_code(stop_code),
        .avg_code(avg_code), .cal_code(cal_code), .force_cal(force_cal),
        .mask_val(mask_val), .clk_ovf_thr(clk_ovf_thr), .coarse_ovf_thr(coarse_ovf_thr),
        .fine_cnt(fine_cnt), .start_in(start_in), .stop_in(stop_in),
        .trig_out(trig_out), .busy(busy), .cal_active(cal_active),
        .done_flag(done_flag), .clk_ovf_flag(clk_ovf_flag),
        .coarse_ovf_flag(coarse_ovf_flag), .acc_flat(acc_flat)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint slot(input int i);
        return longint'(acc_flat[i*AW +: AW]);
    endfunction

    // expected accumulator content from the requirements (R3, R4, R5, R8)
    function automatic longint model_slot(input int i, input int mask, input int code,
                                          input int avg, input int d0, input int gap, input int ne);
        int nstop = (code <= 4) ? code + 1 : 1;
        int taken = 0;
        for (int j = 0; j < ne; j++) begin
            int off = d0 + j * gap;
            if (off >= mask && taken < nstop) begin
                if (taken == i) return longint'(off) * (longint'(1) << avg);
                taken++;
            end
        end
        return 0;
    endfunction

    task automatic pulse_req();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    // one START and a train of STOP pulses, then wait for re-arm or end
    task automatic run_cycle(input int d0, input int gap, input int ne);
        int last = d0 + (ne - 1) * gap;
        start_in = ~start_pol;
        for (int t = 1; t <= last + 1; t++) begin
            bit hit = 1'b0;
            @(negedge clk);
            start_in = start_pol;
            for (int j = 0; j < ne; j++) if (t == d0 + j * gap) hit = 1'b1;
            stop_in = hit ? ~stop_pol : stop_pol;
        end
        @(negedge clk);
        stop_in = stop_pol;
        while (busy && trig_out == trig_pol) begin
            if (cal_active) cal_seen++;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        int ncyc = 1 << v.avg;
        mask_val = v.mask; stop_code = v.code; avg_code = v.avg;
        pulse_req();
        trig_count = 0;
        for (int c = 0; c < ncyc; c++) begin
            if (trig_out != trig_pol) trig_count++;
            if (c > 0) check(done_flag == 1'b0, {tag, " R8 done held low between cycles"}, done_flag, 0);
            run_cycle(int'(v.d0), int'(v.gap), int'(v.ne));
        end
        check(trig_count == ncyc, {tag, " R8 retrigger count"}, trig_count, ncyc);
        check(!busy && done_flag, {tag, " R9 busy clears, done set"}, {busy, done_flag}, 1);
        check(slot(0) == longint'(v.exp0), {tag, " R3 slot0 table value"}, slot(0), v.exp0);
        for (int i = 0; i < NS; i++) begin
            longint e = model_slot(i, v.mask, v.code, v.avg, v.d0, v.gap, v.ne);
            check(slot(i) == e, {tag, " R4 R5 slot model"}, slot(i), e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !cal_active && !done_flag && !clk_ovf_flag && !coarse_ovf_flag,
              "R1 reset flags", {busy, cal_active, done_flag, clk_ovf_flag, coarse_ovf_flag}, 0);
        check(acc_flat == '0, "R1 reset accumulators", slot(0), 0);
        check(trig_out == trig_pol, "R1 reset trigger idle", trig_out, trig_pol);

        // R1 trigger timing
        pulse_req();
        check(busy && trig_out == ~trig_pol, "R1 trigger active after request", trig_out, ~trig_pol);
        start_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(trig_out == ~trig_pol, "R1 trigger held until START seen", trig_out, ~trig_pol);
        @(negedge clk);
        check(trig_out == trig_pol, "R1 trigger released after START", trig_out, trig_pol);
        start_in = 1'b0;
        while (busy) @(negedge clk);

        // table of vectors
        for (int k = 0; k < 6; k++) run_vec(VEC[k], $sformatf("vec%0d", k));

        // R2 no timeout while armed; R9 request while busy ignored
        stop_code = 3'd0; avg_code = 3'd0; mask_val = 16'd0;
        pulse_req();
        repeat (300) @(negedge clk);
        check(busy && trig_out == ~trig_pol, "R2 still armed without START", {busy, trig_out}, 2);
        pulse_req();
        check(busy && trig_out == ~trig_pol && !done_flag, "R9 request while busy ignored", {busy, trig_out}, 2);
        run_cycle(6, 2, 1);
        check(slot(0) == 6 && done_flag, "R2 R9 late START measured", slot(0), 6);

        // R6 overflow boundary: stop at count == threshold kept, then abort
        clk_ovf_thr = 16'd30; stop_code = 3'd1; cal_seen = 0;
        pulse_req();
        run_cycle(30, 2, 2);
        check(clk_ovf_flag && !done_flag && !busy, "R6 clock overflow ends run", {clk_ovf_flag, done_flag}, 2);
        check(slot(0) == 30, "R6 stop at threshold kept", slot(0), 30);
        check(slot(1) == 0, "R6 stop past threshold dropped", slot(1), 0);
        check(cal_seen == 0, "R10 no calibration after abort", cal_seen, 0);

        // R10 forced calibration after overflow, and R9 clear on new start
        force_cal = 1'b1; cal_code = 2'd0; mask_val = 16'd100; stop_code = 3'd0; cal_seen = 0;
        pulse_req();
        check(acc_flat == '0 && !clk_ovf_flag, "R9 new start clears results", slot(0), 0);
        run_cycle(5, 2, 1);
        while (busy) begin
            if (cal_active) cal_seen++;
            @(negedge clk);
        end
        check(cal_seen == 2, "R10 forced calibration length 2", cal_seen, 2);
        check(clk_ovf_flag && acc_flat == '0, "R4 masked stop ignored", slot(0), 0);
        force_cal = 1'b0; clk_ovf_thr = 16'hFFFF; mask_val = 16'd0;

        // R10 normal calibration length 40
        cal_code = 2'd3; cal_seen = 0;
        pulse_req();
        run_cycle(4, 2, 1);
        check(cal_seen == 40, "R10 calibration length 40", cal_seen, 40);
        cal_code = 2'd1;

        // R7 coarse overflow threshold
        coarse_ovf_thr = 16'd10; fine_cnt = 24'd629;
        pulse_req();
        run_cycle(4, 2, 1);
        check(done_flag && !coarse_ovf_flag && slot(0) == 4, "R7 below coarse threshold", coarse_ovf_flag, 0);
        fine_cnt = 24'd630;
        pulse_req();
        run_cycle(4, 2, 1);
        check(coarse_ovf_flag && !clk_ovf_flag && !done_flag, "R7 coarse overflow", coarse_ovf_flag, 1);
        check(slot(0) == 0, "R7 no capture after coarse overflow", slot(0), 0);
        coarse_ovf_thr = 16'hFFFF; fine_cnt = '0;

        // R11 inverted polarities
        @(negedge clk);
        start_pol = 1'b1; start_in = 1'b1; stop_pol = 1'b1; stop_in = 1'b1; trig_pol = 1'b1;
        @(negedge clk);
        check(trig_out == 1'b1, "R11 trigger idles high", trig_out, 1);
        run_vec('{16'd0, 3'd1, 3'd0, 8'd5, 8'd6, 4'd2, 24'd5}, "R11 falling edges");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule